// File: doc/BRIEF.md
# Single-Entry Store Buffer for a Data Cache Array

This block sits between a pipeline's store path and a single-ported data cache data array. A store's doubleword address, data and byte enables are captured in the cycle the store issues. That is also the cycle in which the tag lookup for the store takes place outside the block. The hit or miss result for that store reaches the block one cycle later. A confirmed store is moved into the array on the first cycle in which no load is using the array port. A store that misses is dropped.

The pipeline can issue a store every cycle with no stall. When a new store arrives while an older one is still held, the older one is written out in that same cycle, because a store cycle never carries a load. When a load addresses the doubleword that the buffer holds, the block turns the load's array access into a combined access. The array writes the held bytes while it returns the old contents. One cycle later the block overlays the held bytes on the returned data, so the load sees the store's data with no extra cycle.

The control is a three-state machine:
- EMPTY holds nothing.
- AWAIT_TAG holds a store whose tag result is due in the current cycle.
- PENDING holds a confirmed store that has not yet been written.

The transitions are:
- capture: any state goes to AWAIT_TAG on a store.
- drop: AWAIT_TAG goes to EMPTY when the tag misses.
- drain: AWAIT_TAG or PENDING goes to EMPTY when the port is idle.
- merge: AWAIT_TAG or PENDING goes to EMPTY when a load addresses the same doubleword.
- hold: AWAIT_TAG goes to PENDING, or PENDING stays in PENDING, when a load to another doubleword owns the port.

Top module: `store_hold_buf`

## Requirements
- R1: While reset is held and in the first cycle after it, arr_en, arr_we and ld_rvalid are 0.
- R2: The pipeline presents at most one of st_valid and ld_valid per cycle. Every store is accepted in its own cycle, including stores on consecutive cycles, and every confirmed store ends up in the array.
- R3: A confirmed store is written in the first cycle, at or after the cycle in which tag_hit arrives, in which ld_valid is 0. While a load to a different doubleword owns the port, arr_we stays 0.
- R4: If tag_hit is 0 in the cycle after a store, that store is discarded and never written to the array.
- R5: A store arriving while a confirmed store is held forces arr_we=1 in that cycle, at the held store's address, so the single entry never overflows.
- R6: A load whose address equals the held, confirmed store's address raises arr_we in the load's own cycle, with arr_addr equal to the load address and arr_wbe equal to the store's byte enables. The entry is freed in that cycle.
- R7: ld_rvalid is 1 exactly in the cycle after a load. The array returns, one cycle after arr_en, the doubleword as it was before any write in the same cycle.
- R8: Byte k of the data is bits 8k+7..8k and is affected only when bit k of the byte enable is 1. A merged load returns the held bytes where the enable is set and array bytes elsewhere.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| st_valid | input | 1 | store issues this cycle |
| st_addr | input | AW | store doubleword address |
| st_data | input | DATA_W | store data |
| st_be | input | DATA_W/8 | store byte enables |
| tag_hit | input | 1 | tag result for the previous cycle's store |
| ld_valid | input | 1 | load uses the array this cycle |
| ld_addr | input | AW | load doubleword address |
| arr_en | output | 1 | array access this cycle |
| arr_we | output | 1 | array write this cycle |
| arr_addr | output | AW | array doubleword address |
| arr_wdata | output | DATA_W | array write data |
| arr_wbe | output | DATA_W/8 | array byte write enables |
| arr_rdata | input | DATA_W | array read data, one cycle after arr_en |
| ld_rvalid | output | 1 | load data valid |
| ld_rdata | output | DATA_W | load data, merged with held bytes where required |

## Verification
The hardest state to reach from the ports is a load that lands on the held doubleword in the very cycle its tag result arrives. The same applies when that entry has already been held back by loads to other addresses. The bench reaches both with directed sequences: a store followed by a matching load, and a store followed by loads elsewhere and then a matching load. It follows these with a full sweep of all 256 byte-enable patterns through the merge path. A long random mix of stores, hits, misses and loads over a small array then compares every load against a memory model that the bench keeps arithmetically.

// File: rtl/sbuf_pkg.sv
package sbuf_pkg;

    typedef enum logic [1:0] {
        SB_EMPTY     = 2'd0,
        SB_AWAIT_TAG = 2'd1,
        SB_PENDING   = 2'd2
    } sb_state_e;

    typedef enum logic [2:0] {
        SB_ACT_IDLE  = 3'd0,
        SB_ACT_HOLD  = 3'd1,
        SB_ACT_DRAIN = 3'd2,
        SB_ACT_MERGE = 3'd3,
        SB_ACT_DROP  = 3'd4
    } sb_act_e;

endpackage

// File: rtl/sbuf_entry_fsm.sv
module sbuf_entry_fsm
    import sbuf_pkg::*;
#(
    parameter int AW     = 32,
    parameter int DATA_W = 64,
    parameter int BE_W   = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              st_valid,
    input  logic [AW-1:0]     st_addr,
    input  logic [DATA_W-1:0] st_data,
    input  logic [BE_W-1:0]   st_be,
    input  logic              tag_hit,
    input  logic              ld_valid,
    input  logic [AW-1:0]     ld_addr,
    output sb_state_e         state_o,
    output sb_act_e           act_o,
    output logic [AW-1:0]     ent_addr,
    output logic [DATA_W-1:0] ent_data,
    output logic [BE_W-1:0]   ent_be
);

    sb_state_e state_q;
    sb_state_e state_d;
    sb_act_e   act_c;
    sb_act_e   retire_c;
    logic      ld_same;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SB_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    // Entry storage: a new store always takes the entry
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_addr <= '0;
            ent_data <= '0;
            ent_be   <= '0;
        end else if (st_valid) begin
            ent_addr <= st_addr;
            ent_data <= st_data;
            ent_be   <= st_be;
        end
    end

    // Retirement choice for a confirmed entry
    always_comb begin
        ld_same = ld_valid && (ld_addr == ent_addr);
        if (!ld_valid) begin
            retire_c = SB_ACT_DRAIN;
        end else if (ld_same) begin
            retire_c = SB_ACT_MERGE;
        end else begin
            retire_c = SB_ACT_HOLD;
        end
    end

    // Action and next state
    always_comb begin
        act_c   = SB_ACT_IDLE;
        state_d = state_q;
        unique case (state_q)
            SB_EMPTY: begin
                act_c   = SB_ACT_IDLE;
                state_d = SB_EMPTY;
            end
            SB_AWAIT_TAG: begin
                if (!tag_hit) begin
                    act_c   = SB_ACT_DROP;
                    state_d = SB_EMPTY;
                end else begin
                    act_c   = retire_c;
                    state_d = (retire_c == SB_ACT_HOLD) ? SB_PENDING : SB_EMPTY;
                end
            end
            SB_PENDING: begin
                act_c   = retire_c;
                state_d = (retire_c == SB_ACT_HOLD) ? SB_PENDING : SB_EMPTY;
            end
            default: begin
                act_c   = SB_ACT_IDLE;
                state_d = SB_EMPTY;
            end
        endcase
        if (st_valid) begin
            state_d = SB_AWAIT_TAG;
        end
    end

    assign state_o = state_q;
    assign act_o   = act_c;

    // A held store never survives a cycle in which nothing else uses the port
    assert_no_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SB_PENDING && !ld_valid) |=> (state_q != SB_PENDING || $past(st_valid)));

endmodule

// File: rtl/sbuf_port_mux.sv
module sbuf_port_mux
    import sbuf_pkg::*;
#(
    parameter int AW     = 32,
    parameter int DATA_W = 64,
    parameter int BE_W   = DATA_W / 8
) (
    input  sb_act_e           act,
    input  logic              ld_valid,
    input  logic [AW-1:0]     ld_addr,
    input  logic [AW-1:0]     ent_addr,
    input  logic [DATA_W-1:0] ent_data,
    input  logic [BE_W-1:0]   ent_be,
    output logic              arr_en,
    output logic              arr_we,
    output logic [AW-1:0]     arr_addr,
    output logic [DATA_W-1:0] arr_wdata,
    output logic [BE_W-1:0]   arr_wbe
);

    logic wr_c;

    always_comb begin
        wr_c      = (act == SB_ACT_DRAIN) || (act == SB_ACT_MERGE);
        arr_en    = ld_valid || wr_c;
        arr_we    = wr_c;
        arr_addr  = ld_valid ? ld_addr : ent_addr;
        arr_wdata = ent_data;
        arr_wbe   = wr_c ? ent_be : '0;
    end

endmodule

// File: rtl/sbuf_load_merge.sv
module sbuf_load_merge #(
    parameter int DATA_W = 64,
    parameter int BE_W   = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_valid,
    input  logic              merge,
    input  logic [DATA_W-1:0] ent_data,
    input  logic [BE_W-1:0]   ent_be,
    input  logic [DATA_W-1:0] arr_rdata,
    output logic              ld_rvalid,
    output logic [DATA_W-1:0] ld_rdata
);

    localparam int LANE_W = DATA_W / BE_W;

    logic              rv_q;
    logic [DATA_W-1:0] fdata_q;
    logic [BE_W-1:0]   fbe_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rv_q    <= 1'b0;
            fdata_q <= '0;
            fbe_q   <= '0;
        end else begin
            rv_q    <= ld_valid;
            fdata_q <= ent_data;
            fbe_q   <= merge ? ent_be : '0;
        end
    end

    for (genvar k = 0; k < BE_W; k++) begin : g_lane
        assign ld_rdata[k*LANE_W +: LANE_W] = fbe_q[k] ? fdata_q[k*LANE_W +: LANE_W]
                                                       : arr_rdata[k*LANE_W +: LANE_W];
    end

    assign ld_rvalid = rv_q;

endmodule

// File: rtl/store_hold_buf.sv
module store_hold_buf
    import sbuf_pkg::*;
#(
    parameter int AW     = 32,
    parameter int DATA_W = 64
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  st_valid,
    input  logic [AW-1:0]         st_addr,
    input  logic [DATA_W-1:0]     st_data,
    input  logic [DATA_W/8-1:0]   st_be,
    input  logic                  tag_hit,
    input  logic                  ld_valid,
    input  logic [AW-1:0]         ld_addr,
    output logic                  arr_en,
    output logic                  arr_we,
    output logic [AW-1:0]         arr_addr,
    output logic [DATA_W-1:0]     arr_wdata,
    output logic [DATA_W/8-1:0]   arr_wbe,
    input  logic [DATA_W-1:0]     arr_rdata,
    output logic                  ld_rvalid,
    output logic [DATA_W-1:0]     ld_rdata
);

    localparam int BE_W = DATA_W / 8;

    sb_state_e         state;
    sb_act_e           act;
    logic [AW-1:0]     ent_addr;
    logic [DATA_W-1:0] ent_data;
    logic [BE_W-1:0]   ent_be;
    logic              merge;

    sbuf_entry_fsm #(.AW(AW), .DATA_W(DATA_W), .BE_W(BE_W)) fsm_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .st_valid (st_valid),
        .st_addr  (st_addr),
        .st_data  (st_data),
        .st_be    (st_be),
        .tag_hit  (tag_hit),
        .ld_valid (ld_valid),
        .ld_addr  (ld_addr),
        .state_o  (state),
        .act_o    (act),
        .ent_addr (ent_addr),
        .ent_data (ent_data),
        .ent_be   (ent_be)
    );

    sbuf_port_mux #(.AW(AW), .DATA_W(DATA_W), .BE_W(BE_W)) mux_i (
        .act       (act),
        .ld_valid  (ld_valid),
        .ld_addr   (ld_addr),
        .ent_addr  (ent_addr),
        .ent_data  (ent_data),
        .ent_be    (ent_be),
        .arr_en    (arr_en),
        .arr_we    (arr_we),
        .arr_addr  (arr_addr),
        .arr_wdata (arr_wdata),
        .arr_wbe   (arr_wbe)
    );

    assign merge = (act == SB_ACT_MERGE);

    sbuf_load_merge #(.DATA_W(DATA_W), .BE_W(BE_W)) merge_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_valid  (ld_valid),
        .merge     (merge),
        .ent_data  (ent_data),
        .ent_be    (ent_be),
        .arr_rdata (arr_rdata),
        .ld_rvalid (ld_rvalid),
        .ld_rdata  (ld_rdata)
    );

    assert_single_op_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_valid && ld_valid));

    assert_idle_retire_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SB_PENDING && !ld_valid) |-> (arr_we && arr_addr == ent_addr));

    assert_port_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && ld_addr != ent_addr) |-> !arr_we);

    assert_miss_no_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SB_AWAIT_TAG && !tag_hit) |-> !arr_we);

    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && (state == SB_PENDING || (state == SB_AWAIT_TAG && tag_hit)))
            |-> (arr_we && arr_addr == ent_addr));

    assert_combined_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && ld_addr == ent_addr &&
         (state == SB_PENDING || (state == SB_AWAIT_TAG && tag_hit)))
            |-> (arr_we && arr_addr == ld_addr && arr_wbe == ent_be));

    assert_rvalid_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |=> ld_rvalid);

    assert_rvalid_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_valid |=> !ld_rvalid);

endmodule

// File: tb/store_hold_buf_tb_top.sv
`timescale 1ns/1ps
module store_hold_buf_tb_top;

    localparam int AW    = 3;
    localparam int DW    = 64;
    localparam int BW    = DW / 8;
    localparam int DEPTH = 1 << AW;
    localparam int OP_IDLE = 0;
    localparam int OP_ST   = 1;
    localparam int OP_LD   = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          st_valid = 1'b0;
    logic [AW-1:0] st_addr = '0;
    logic [DW-1:0] st_data = '0;
    logic [BW-1:0] st_be = '0;
    logic          tag_hit = 1'b0;
    logic          ld_valid = 1'b0;
    logic [AW-1:0] ld_addr = '0;
    logic          arr_en, arr_we, ld_rvalid;
    logic [AW-1:0] arr_addr;
    logic [DW-1:0] arr_wdata, ld_rdata;
    logic [BW-1:0] arr_wbe;
    logic [DW-1:0] arr_rdata = '0;

    logic [DW-1:0] amem [DEPTH];
    logic [DW-1:0] gold [DEPTH];

    int  errors = 0;
    int  checks = 0;
    bit  done = 0;
    bit  nxt_hit = 0;
    bit  exp_rv = 0;
    logic [DW-1:0] exp_rd = '0;

    always #2.5 clk = ~clk;

    store_hold_buf #(.AW(AW), .DATA_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_addr(st_addr),
        .st_data(st_data), .st_be(st_be), .tag_hit(tag_hit),
        .ld_valid(ld_valid), .ld_addr(ld_addr), .arr_en(arr_en), .arr_we(arr_we),
        .arr_addr(arr_addr), .arr_wdata(arr_wdata), .arr_wbe(arr_wbe),
        .arr_rdata(arr_rdata), .ld_rvalid(ld_rvalid), .ld_rdata(ld_rdata)
    );

    // Array model: registered read of pre-write contents, byte-masked write
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) amem[i] <= '0;
        end else begin
            if (arr_en) arr_rdata <= amem[arr_addr];
            if (arr_we) begin
                for (int b = 0; b < BW; b++)
                    if (arr_wbe[b]) amem[arr_addr][b*8 +: 8] <= arr_wdata[b*8 +: 8];
            end
        end
    end

    function automatic logic [DW-1:0] overlay(input logic [DW-1:0] old,
                                              input logic [DW-1:0] d,
                                              input logic [BW-1:0] be);
        logic [DW-1:0] r;
        r = old;
        for (int b = 0; b < BW; b++)
            if (be[b]) r[b*8 +: 8] = d[b*8 +: 8];
        return r;
    endfunction

    task automatic chk(input string rq, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    // One cycle: check last load, drive new op, leave outputs settled for the caller
    task automatic step(input int op, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input logic [BW-1:0] be, input bit hit);
        @(negedge clk);
        chk("R7 ld_rvalid", {63'd0, ld_rvalid}, {63'd0, exp_rv});
        if (exp_rv) chk("R2/R6/R8 load data", ld_rdata, exp_rd);
        st_valid = (op == OP_ST);
        ld_valid = (op == OP_LD);
        st_addr  = a;
        ld_addr  = a;
        st_data  = d;
        st_be    = be;
        tag_hit  = nxt_hit;
        nxt_hit  = (op == OP_ST) ? hit : 1'b0;
        if (op == OP_ST && hit) gold[a] = overlay(gold[a], d, be);
        exp_rv = (op == OP_LD);
        exp_rd = gold[a];
        #1;
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) gold[i] = '0;
        repeat (3) @(negedge clk);
        chk("R1 arr_en in reset", {63'd0, arr_en}, 64'd0);
        chk("R1 ld_rvalid in reset", {63'd0, ld_rvalid}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk("R1 arr_we after reset", {63'd0, arr_we}, 64'd0);

        // R3: held behind loads elsewhere, written on first idle cycle
        step(OP_ST, 3'd1, 64'h1111_2222_3333_4444, 8'hFF, 1);
        step(OP_LD, 3'd2, '0, '0, 0);
        chk("R3 no write under load", {63'd0, arr_we}, 64'd0);
        step(OP_LD, 3'd3, '0, '0, 0);
        chk("R3 still held", {63'd0, arr_we}, 64'd0);
        step(OP_IDLE, '0, '0, '0, 0);
        chk("R3 idle drain", {63'd0, arr_we}, 64'd1);
        chk("R3 drain addr", {61'd0, arr_addr}, 64'd1);
        step(OP_IDLE, '0, '0, '0, 0);
        chk("R3 array content", amem[1], gold[1]);

        // R4: tag miss discards
        step(OP_ST, 3'd4, 64'hDEAD_BEEF_0000_0001, 8'hFF, 0);
        step(OP_IDLE, '0, '0, '0, 0);
        chk("R4 no write on miss", {63'd0, arr_we}, 64'd0);
        step(OP_IDLE, '0, '0, '0, 0);
        chk("R4 no later write", {63'd0, arr_we}, 64'd0);
        chk("R4 array untouched", amem[4], 64'd0);

        // R5: store while a confirmed store is held
        step(OP_ST, 3'd5, 64'h5555_5555_5555_5555, 8'h0F, 1);
        step(OP_LD, 3'd6, '0, '0, 0);
        step(OP_ST, 3'd6, 64'h6666_6666_6666_6666, 8'hF0, 1);
        chk("R5 forced write", {63'd0, arr_we}, 64'd1);
        chk("R5 forced addr", {61'd0, arr_addr}, 64'd5);
        step(OP_IDLE, '0, '0, '0, 0);
        chk("R5 second drains", {63'd0, arr_we}, 64'd1);

        // R6: store then load to the same doubleword (tag arrives in load cycle)
        step(OP_ST, 3'd2, 64'hAAAA_BBBB_CCCC_DDDD, 8'h0F, 1);
        step(OP_LD, 3'd2, '0, '0, 0);
        chk("R6 combined write", {63'd0, arr_we}, 64'd1);
        chk("R6 combined addr", {61'd0, arr_addr}, 64'd2);
        chk("R6 combined be", {56'd0, arr_wbe}, 64'h0F);
        // R6 from PENDING after being held
        step(OP_ST, 3'd7, 64'h7777_0000_7777_0000, 8'h3C, 1);
        step(OP_LD, 3'd0, '0, '0, 0);
        step(OP_LD, 3'd7, '0, '0, 0);
        chk("R6 merge from pending", {63'd0, arr_we}, 64'd1);
        step(OP_IDLE, '0, '0, '0, 0);

        // R2: back-to-back stores, mixed hits, then read all
        for (int i = 0; i < 16; i++)
            step(OP_ST, 3'(i), {8{8'(i * 37 + 5)}}, 8'(i * 29 + 1), (i % 3) != 1);
        for (int i = 0; i < DEPTH; i++) step(OP_LD, 3'(i), '0, '0, 0);

        // R8: every byte-enable pattern through the merge path
        for (int be = 0; be < 256; be++) begin
            step(OP_ST, 3'(be), {be[7:0], 8'h11, be[7:0], 8'h22, be[7:0], 8'h33, be[7:0], 8'h44},
                 8'(be), 1);
            step(OP_LD, 3'(be), '0, '0, 0);
        end

        // Random mix
        for (int i = 0; i < 4000; i++) begin
            int r;
            r = $urandom_range(0, 9);
            if (r < 4)
                step(OP_ST, 3'($urandom), {$urandom, $urandom}, 8'($urandom), $urandom_range(0, 3) != 0);
            else if (r < 8)
                step(OP_LD, 3'($urandom), '0, '0, 0);
            else
                step(OP_IDLE, '0, '0, '0, 0);
        end
        step(OP_IDLE, '0, '0, '0, 0);
        step(OP_IDLE, '0, '0, '0, 0);
        for (int i = 0; i < DEPTH; i++) chk("R2 final array", amem[i], gold[i]);
        for (int i = 0; i < DEPTH; i++) step(OP_LD, 3'(i), '0, '0, 0);
        step(OP_IDLE, '0, '0, '0, 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule